// File: doc/BRIEF.md
# Drive LED Serial Streamer

The block keeps one LED pattern for a set of storage ports and sends it to an enclosure controller over three wires: a shift clock, a load strobe and a data line. Each port owns three pattern bits (activity, locate, fault). They sit in a slot picked by a per-port mapping table, so the wiring order of the enclosure can differ from the port numbering.

A request carries a port number and a 32-bit state word. The block decodes the word into the port's three LED bits and merges them into the stored pattern. In the same cycle it captures the merged pattern and the two dummy-clock counts for the frame that follows. A frame holds a programmable number of leading dummy clocks, one clock with the load strobe high, one data bit per clock (least significant bit first) and a programmable number of trailing dummy clocks. Each clock is high for `HALF_CYC` system cycles and then low for the same time. Between frames all three lines rest high. Requests offered during a frame are refused through `req_ready`.

Top module: `drive_led_streamer`

## Requirements
- R1: Out of reset and between frames, `sclk`, `sload` and `sdata` are all 1, `busy` is 0 and `req_ready` is 1.
- R2: The state word decodes as follows. Activity is 1 when bit 20 or bit 21 is set. Locate is 1 when bit 19 is set. Fault is 1 when bit 22 is set. Each is 0 when its bits are clear, and all other bits have no effect.
- R3: The slot of port p is `slot_map[3p+2:3p]`. An update writes activity, locate and fault to pattern bits 3·slot+0, 3·slot+1 and 3·slot+2, and leaves every other pattern bit unchanged.
- R4: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle. While `busy` is 1, `req_ready` is 0 and `req_valid` has no effect on the pattern.
- R5: Each shift-clock cycle is high for `HALF_CYC` system cycles and then low for `HALF_CYC` system cycles. The first cycle of a frame starts high.
- R6: A frame runs in this order: `pre_clocks` clocks with `sload` 0, one clock with `sload` 1, 3·`NUM_PORTS` data clocks, then `post_clocks` clocks. Either count may be 0. Both counts are sampled when the request is taken.
- R7: `sload` and `sdata` are constant across each whole shift-clock cycle, so they are stable at its falling edge, where the receiver latches. `sdata` is 1 in every clock that is not a data clock.
- R8: Data clock i carries pattern bit i. The frame uses the pattern as it stands after merging the request that started the frame.
- R9: A frame lasts 2·`HALF_CYC`·(pre+1+3·`NUM_PORTS`+post) cycles of `busy`. After it, the lines return high and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Update request offered |
| req_ready | output | 1 | Block can take a request |
| req_port | input | PORT_W | Port the request updates |
| req_state | input | 32 | State word to decode |
| slot_map | input | 3·NUM_PORTS | Three-bit slot number per port |
| pre_clocks | input | CNT_W | Dummy clocks before the load clock |
| post_clocks | input | CNT_W | Dummy clocks after the data |
| sclk | output | 1 | Shift clock to the enclosure |
| sload | output | 1 | Frame-start load strobe |
| sdata | output | 1 | Serial pattern data |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with eight ports, `HALF_CYC` = 2 and 3-bit dummy counts. This keeps a full frame under 160 cycles, so every port can be tried with every combination of the three LED bits. That sweep runs under two different slot mappings, and the dummy counts cover their whole 0–7 range, including zero. A reference pattern built from the decode and slot rules is compared bit by bit with the values latched at each falling shift-clock edge. The spacing of those edges is checked against the half period, and requests offered in the middle of a frame must leave no mark on the next frame.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int LED_BITS  = 3;
    localparam int MAX_SLOTS = 8;
    localparam int SLOT_W    = 3;

    localparam logic [31:0] ACT_MASK = 32'h0030_0000;
    localparam logic [31:0] LOC_MASK = 32'h0008_0000;
    localparam logic [31:0] FLT_MASK = 32'h0040_0000;

    // bit 0 activity, bit 1 locate, bit 2 fault
    typedef struct packed {
        logic fault;
        logic locate;
        logic act;
    } led_trio_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_LOAD,
        PH_DATA,
        PH_POST
    } frame_phase_e;

    function automatic led_trio_t decode_state(input logic [31:0] word);
        led_trio_t t;
        t.act    = |(word & ACT_MASK);
        t.locate = |(word & LOC_MASK);
        t.fault  = |(word & FLT_MASK);
        return t;
    endfunction

endpackage

// File: rtl/dls_pattern_store.sv
module dls_pattern_store
    import dls_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3,
    parameter int PAT_W     = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_en,
    input  logic [PORT_W-1:0]           upd_port,
    input  logic [31:0]                 upd_word,
    input  logic [NUM_PORTS*SLOT_W-1:0] slot_map,
    output logic [PAT_W-1:0]            next_pat
);

    logic [PAT_W-1:0]  pat_q;
    led_trio_t         trio;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        trio     = decode_state(upd_word);
        slot     = slot_map[int'(upd_port)*SLOT_W +: SLOT_W];
        next_pat = pat_q;
        for (int k = 0; k < LED_BITS; k++) begin
            next_pat[int'(slot)*LED_BITS + k] = trio[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (upd_en) begin
            pat_q <= next_pat;
        end
    end

endmodule

// File: rtl/dls_half_timer.sv
module dls_half_timer #(
    parameter int HALF_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic clk_hi,
    output logic cyc_done
);

    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] LAST = HC_W'(HALF_CYC - 1);

    logic [HC_W-1:0] hcnt;
    logic            low_half;
    logic            half_end;

    assign half_end = (hcnt == LAST);
    assign cyc_done = run && half_end && low_half;
    assign clk_hi   = ~low_half;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt     <= '0;
            low_half <= 1'b0;
        end else if (half_end) begin
            hcnt     <= '0;
            low_half <= ~low_half;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/dls_frame_seq.sv
module dls_frame_seq
    import dls_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int DATA_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CNT_W-1:0]     pre_cnt,
    input  logic [CNT_W-1:0]     post_cnt,
    input  logic [DATA_BITS-1:0] frame_pat,
    input  logic                 cyc_done,
    output frame_phase_e         phase,
    output logic                 cur_bit
);

    localparam int DB_W  = $clog2(DATA_BITS);
    localparam int IDX_W = ((DB_W > CNT_W) ? DB_W : CNT_W) + 1;
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BITS - 1);

    logic [IDX_W-1:0]     idx;
    logic [CNT_W-1:0]     pre_q;
    logic [CNT_W-1:0]     post_q;
    logic [DATA_BITS-1:0] shreg;
    logic                 last_pre;
    logic                 last_post;

    assign last_pre  = (idx == IDX_W'(pre_q) - IDX_W'(1));
    assign last_post = (idx == IDX_W'(post_q) - IDX_W'(1));
    assign cur_bit   = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            pre_q  <= '0;
            post_q <= '0;
            shreg  <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase  <= (pre_cnt != '0) ? PH_PRE : PH_LOAD;
                idx    <= '0;
                pre_q  <= pre_cnt;
                post_q <= post_cnt;
                shreg  <= frame_pat;
            end
        end else if (cyc_done) begin
            unique case (phase)
                PH_PRE: begin
                    if (last_pre) begin
                        phase <= PH_LOAD;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_LOAD: begin
                    phase <= PH_DATA;
                    idx   <= '0;
                end
                PH_DATA: begin
                    shreg <= {1'b0, shreg[DATA_BITS-1:1]};
                    if (idx == LAST_DATA) begin
                        phase <= (post_q != '0) ? PH_POST : PH_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_POST: begin
                    if (last_post) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/drive_led_streamer.sv
module drive_led_streamer
    import dls_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int HALF_CYC  = 16,
    parameter int CNT_W     = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [PORT_W-1:0]             req_port,
    input  logic [31:0]                   req_state,
    input  logic [NUM_PORTS*SLOT_W-1:0]   slot_map,
    input  logic [CNT_W-1:0]              pre_clocks,
    input  logic [CNT_W-1:0]              post_clocks,
    output logic                          sclk,
    output logic                          sload,
    output logic                          sdata,
    output logic                          busy
);

    localparam int PAT_W     = MAX_SLOTS * LED_BITS;
    localparam int DATA_BITS = NUM_PORTS * LED_BITS;

    logic             accept;
    logic             idle;
    logic [PAT_W-1:0] next_pat;
    logic             clk_hi;
    logic             cyc_done;
    logic             cur_bit;
    frame_phase_e     phase;

    assign idle      = (phase == PH_IDLE);
    assign busy      = ~idle;
    assign req_ready = idle;
    assign accept    = req_valid && idle;

    dls_pattern_store #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .PAT_W     (PAT_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (accept),
        .upd_port (req_port),
        .upd_word (req_state),
        .slot_map (slot_map),
        .next_pat (next_pat)
    );

    dls_half_timer #(
        .HALF_CYC (HALF_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .clk_hi   (clk_hi),
        .cyc_done (cyc_done)
    );

    dls_frame_seq #(
        .CNT_W     (CNT_W),
        .DATA_BITS (DATA_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .pre_cnt   (pre_clocks),
        .post_cnt  (post_clocks),
        .frame_pat (next_pat[DATA_BITS-1:0]),
        .cyc_done  (cyc_done),
        .phase     (phase),
        .cur_bit   (cur_bit)
    );

    assign sclk  = idle | clk_hi;
    assign sload = idle | (phase == PH_LOAD);
    assign sdata = (phase != PH_DATA) | cur_bit;

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int HALF_CYC = 16
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic sclk,
    input logic sload,
    input logic sdata
);

    logic [15:0] run_len;
    logic        prev_sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            prev_sclk <= 1'b1;
        end else begin
            prev_sclk <= sclk;
            if (sclk != prev_sclk) begin
                run_len <= 16'd1;
            end else if (run_len != 16'hFFFF) begin
                run_len <= run_len + 16'd1;
            end
        end
    end

    // R1
    idle_lines_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && sload && sdata));

    // R4
    start_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R5
    low_half_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (run_len == 16'(HALF_CYC)));

    // R7
    stable_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $fell(sclk)) |-> ($stable(sdata) && $stable(sload)));

    // R7
    data_high_at_load_chk: assert property (@(posedge clk) disable iff (rst)
        sload |-> sdata);

endmodule

bind drive_led_streamer dls_checker #(.HALF_CYC(HALF_CYC)) u_dls_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .sclk      (sclk),
    .sload     (sload),
    .sdata     (sdata)
);

// File: tb/test_drive_led_streamer.sv
`timescale 1ns/1ps
module test_drive_led_streamer;

    localparam int NP   = 8;
    localparam int HC   = 2;
    localparam int CW   = 3;
    localparam int DB   = NP * 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [2:0]     req_port = '0;
    logic [31:0]    req_state = '0;
    logic [NP*3-1:0] slot_map = '0;
    logic [CW-1:0]  pre_clocks = '0;
    logic [CW-1:0]  post_clocks = '0;
    logic           sclk, sload, sdata, busy;

    always #2 clk = ~clk;

    drive_led_streamer #(
        .NUM_PORTS (NP),
        .HALF_CYC  (HC),
        .CNT_W     (CW)
    ) i_drive_led_streamer (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_port    (req_port),
        .req_state   (req_state),
        .slot_map    (slot_map),
        .pre_clocks  (pre_clocks),
        .post_clocks (post_clocks),
        .sclk        (sclk),
        .sload       (sload),
        .sdata       (sdata),
        .busy        (busy)
    );

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    int nf    = 0;
    int busy_cyc = 0;
    int bstart = 0;
    logic prev_sclk = 1'b1;
    logic prev_busy = 1'b0;
    logic fall_ld [64];
    logic fall_dt [64];
    int   fall_t  [64];
    logic [DB-1:0] model = '0;
    int   map_kind = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input int p, input int kind);
        return (kind != 0) ? (7 - p) : ((3 * p + 1) % 8);
    endfunction

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (busy) busy_cyc++;
        if (busy && !prev_busy) bstart = cyc;
        if (prev_sclk && !sclk && nf < 64) begin
            fall_ld[nf] = sload;
            fall_dt[nf] = sdata;
            fall_t[nf]  = cyc;
            nf++;
        end
        prev_sclk = sclk;
        prev_busy = busy;
        if (cyc == 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic set_map(input int kind);
        map_kind = kind;
        for (int p = 0; p < NP; p++) slot_map[p*3 +: 3] = 3'(slot_of(p, kind));
    endtask

    task automatic model_update(input int p, input logic [31:0] st);
        int s;
        s = slot_of(p, map_kind);
        // R2 decode: act bits 21:20, locate bit 19, fault bit 22
        model[s*3 + 0] = st[20] | st[21];
        model[s*3 + 1] = st[19];
        model[s*3 + 2] = st[22];
    endtask

    task automatic run_frame(input int p, input logic [31:0] st, input int pre,
                             input int post, input bit noise);
        int total;
        logic [DB-1:0] got;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nf = 0;
        busy_cyc = 0;
        req_port    = 3'(p);
        req_state   = st;
        pre_clocks  = CW'(pre);
        post_clocks = CW'(post);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        model_update(p, st);
        // R4: busy one cycle after acceptance, ready low
        chk(busy && !req_ready, "R4 busy after accept", {busy, req_ready}, 2'b10);
        // counts changed mid-frame must not matter (R6)
        pre_clocks  = CW'(7 - pre);
        post_clocks = CW'(7 - post);
        if (noise) begin
            req_port  = 3'((p + 1) % NP);
            req_state = ~req_state;
            req_valid = 1'b1;
            repeat (10) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        total = pre + 1 + DB + post;
        chk(nf == total, "R6 clock count", 64'(nf), 64'(total));
        chk(busy_cyc == 2 * HC * total, "R9 frame duration", 64'(busy_cyc), 64'(2*HC*total));
        chk(sclk && sload && sdata && req_ready, "R1 R9 lines high after frame",
            {sclk, sload, sdata, req_ready}, 4'hF);
        if (nf == total) begin
            for (int i = 0; i < total; i++) begin
                chk(fall_ld[i] == (i == pre), "R6 load strobe position",
                    64'(fall_ld[i]), 64'(i == pre));
                if (i <= pre || i > pre + DB)
                    chk(fall_dt[i] == 1'b1, "R7 sdata high outside data",
                        64'(fall_dt[i]), 64'd1);
                if (i == 0)
                    chk(fall_t[0] - bstart == HC, "R5 first high half",
                        64'(fall_t[0] - bstart), 64'(HC));
                else
                    chk(fall_t[i] - fall_t[i-1] == 2 * HC, "R5 clock period",
                        64'(fall_t[i] - fall_t[i-1]), 64'(2*HC));
            end
            for (int i = 0; i < DB; i++) got[i] = fall_dt[pre + 1 + i];
            chk(got == model, "R3 R8 frame data", 64'(got), 64'(model));
        end
    endtask

    initial begin
        set_map(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk && sload && sdata && !busy && req_ready, "R1 reset state",
            {sclk, sload, sdata, busy, req_ready}, 5'b11101);

        for (int kind = 0; kind < 2; kind++) begin
            set_map(kind);
            for (int p = 0; p < NP; p++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [31:0] st;
                    st = '0;
                    if (c[0]) st[(p % 2 == 1) ? 21 : 20] = 1'b1;
                    if (c[1]) st[19] = 1'b1;
                    if (c[2]) st[22] = 1'b1;
                    // R2: bits outside the masks have no effect
                    if (((p + c) % 2) == 1) st = st | 32'hFF87_FFFF;
                    run_frame(p, st, (p + c) % 8, (p * 3 + c) % 8, c == 5);
                end
            end
        end

        // R2: both activity bits set, R4 ignored request followed by a clean frame
        run_frame(2, 32'h0030_0000, 0, 0, 1'b1);
        run_frame(6, 32'h0000_0000, 7, 7, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule